// File: doc/BRIEF.md
# Latest CAN Event Status Register

This block is an 8-bit status register inside a CAN-style controller. It remembers which kind of event the controller core reported most recently: a change of node state, the end of a frame transmission, or the arrival of a frame. For the two completion kinds it also stores the number of the message buffer that finished. The core drives a single-cycle node-change strobe and two 16-bit per-buffer completion vectors. The flags are recorded whether or not the matching interrupts are enabled.

Software reads the register over a simple register bus that has read, write and read-modify-write qualifiers. Software can only clear bits, by writing zero to them. Writing one to a bit leaves it unchanged. A read that is part of a read-modify-write returns ones in every implemented bit, so the write that follows cannot clear anything by accident. Each new event replaces the whole record, so exactly one flag always marks the newest event. An interrupt handler should still expect that a later event may have replaced the one that raised its interrupt.

Top module: `levt_reg`

## Requirements
- R1: A synchronous active-high reset (`rst`) sets the register to 0x00.
- R2: A node-change strobe alone makes the register read 0x80 on the next cycle. Bit 7 is set, bits 6 and 5 are cleared and the buffer number in bits 3..0 is 0.
- R3: When any transmit-done bit is set and no receive-done bit is set, the register reads 0x40 plus the buffer number on the next cycle. Bit 6 is set, bits 7 and 5 are cleared and the buffer number is in bits 3..0.
- R4: When any receive-done bit is set, the register reads 0x20 plus the buffer number on the next cycle. Bit 5 is set, bits 7 and 6 are cleared and the buffer number is in bits 3..0.
- R5: When several buffers in one completion vector are set together, the lowest-numbered buffer is recorded.
- R6: Events in the same cycle are ranked receive first, then transmit, then node change.
- R7: A bus write with no event in that cycle sets each implemented bit to its old value ANDed with the written bit. Writing 0 clears the bit and writing 1 leaves it unchanged.
- R8: Bit 4 always reads 0 and ignores writes.
- R9: When the read-modify-write qualifier is high, the combinational read data is 0xEF. Otherwise the read data equals the register value.
- R10: When an event and a bus write fall in the same cycle, the event's record is stored and the write has no effect.
- R11: With no event and no write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_evt_i | input | 1 | Node-state change strobe |
| tx_done_i | input | 16 | Per-buffer transmit completion strobes |
| rx_done_i | input | 16 | Per-buffer receive completion strobes |
| bus_rd_i | input | 1 | Register read qualifier |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rmw_i | input | 1 | Read-modify-write qualifier |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| stat_o | output | 8 | Current register value |

## Verification
Events and writes are stored on the clock edge that follows the cycle in which they are presented, so `stat_o` shows the result one edge later. Read data, including the forced 0xEF during a read-modify-write, is combinational and appears in the same cycle as its qualifier. The bench drives inputs on the falling edge and removes them on the next falling edge. It then checks the registered result, which by that point has passed exactly one rising edge. Read data is checked 1 ns after the qualifier changes, before any rising edge occurs.

// File: rtl/levt_pkg.sv
package levt_pkg;

    localparam int BUF_CNT = 16;
    localparam int IDX_W   = $clog2(BUF_CNT);

    // Register image: bit 7 node, bit 6 tx, bit 5 rx, bit 4 reserved, 3..0 index
    typedef struct packed {
        logic             node;
        logic             tx;
        logic             rx;
        logic             rsv;
        logic [IDX_W-1:0] idx;
    } rec_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_NODE = 2'd1,
        EV_TX   = 2'd2,
        EV_RX   = 2'd3
    } ev_kind_t;

    localparam logic [7:0] IMPL_MASK = 8'hEF;

    function automatic rec_t make_rec(ev_kind_t kind, logic [IDX_W-1:0] idx);
        rec_t r;
        r      = '0;
        r.node = (kind == EV_NODE);
        r.tx   = (kind == EV_TX);
        r.rx   = (kind == EV_RX);
        r.idx  = (kind == EV_NODE) ? '0 : idx;
        return r;
    endfunction

endpackage

// File: rtl/levt_prio_enc.sv
module levt_prio_enc #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = W'(i);
        end
    end

    assign any_o = |vec_i;
endmodule

// File: rtl/levt_event_sel.sv
module levt_event_sel
    import levt_pkg::*;
#(
    parameter int NBUF = BUF_CNT
) (
    input  logic            node_evt_i,
    input  logic [NBUF-1:0] tx_done_i,
    input  logic [NBUF-1:0] rx_done_i,
    output logic            ev_o,
    output rec_t            rec_o
);
    localparam int IW = $clog2(NBUF);

    logic          tx_any, rx_any;
    logic [IW-1:0] tx_idx, rx_idx;
    ev_kind_t      kind;
    logic [IW-1:0] sel_idx;

    levt_prio_enc #(.N(NBUF), .W(IW)) tx_enc_i (
        .vec_i (tx_done_i),
        .any_o (tx_any),
        .idx_o (tx_idx)
    );

    levt_prio_enc #(.N(NBUF), .W(IW)) rx_enc_i (
        .vec_i (rx_done_i),
        .any_o (rx_any),
        .idx_o (rx_idx)
    );

    always_comb begin
        if (rx_any) begin
            kind    = EV_RX;
            sel_idx = rx_idx;
        end else if (tx_any) begin
            kind    = EV_TX;
            sel_idx = tx_idx;
        end else if (node_evt_i) begin
            kind    = EV_NODE;
            sel_idx = '0;
        end else begin
            kind    = EV_NONE;
            sel_idx = '0;
        end
    end

    assign ev_o  = (kind != EV_NONE);
    assign rec_o = make_rec(kind, IDX_W'(sel_idx));
endmodule

// File: rtl/levt_cpu_port.sv
module levt_cpu_port
    import levt_pkg::*;
(
    input  rec_t       cur_i,
    input  logic       bus_rmw_i,
    input  logic [7:0] bus_wdata_i,
    output rec_t       wr_next_o,
    output logic [7:0] rdata_o
);
    always_comb begin
        wr_next_o = rec_t'(cur_i & bus_wdata_i & IMPL_MASK);
    end

    assign rdata_o = bus_rmw_i ? IMPL_MASK : (cur_i & IMPL_MASK);
endmodule

// File: rtl/levt_reg.sv
module levt_reg
    import levt_pkg::*;
#(
    parameter int NBUF = BUF_CNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            node_evt_i,
    input  logic [NBUF-1:0] tx_done_i,
    input  logic [NBUF-1:0] rx_done_i,
    input  logic            bus_rd_i,
    input  logic            bus_wr_i,
    input  logic            bus_rmw_i,
    input  logic [7:0]      bus_wdata_i,
    output logic [7:0]      bus_rdata_o,
    output logic [7:0]      stat_o
);
    rec_t cur_q, ev_rec, wr_rec;
    logic ev;
    logic rd_unused;

    assign rd_unused = bus_rd_i;

    levt_event_sel #(.NBUF(NBUF)) sel_i (
        .node_evt_i (node_evt_i),
        .tx_done_i  (tx_done_i),
        .rx_done_i  (rx_done_i),
        .ev_o       (ev),
        .rec_o      (ev_rec)
    );

    levt_cpu_port port_i (
        .cur_i       (cur_q),
        .bus_rmw_i   (bus_rmw_i),
        .bus_wdata_i (bus_wdata_i),
        .wr_next_o   (wr_rec),
        .rdata_o     (bus_rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst)           cur_q <= '0;
        else if (ev)       cur_q <= ev_rec;
        else if (bus_wr_i) cur_q <= wr_rec;
    end

    assign stat_o = cur_q;
endmodule

// File: rtl/levt_reg_chk.sv
module levt_reg_chk #(
    parameter int NBUF = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            node_evt_i,
    input logic [NBUF-1:0] tx_done_i,
    input logic [NBUF-1:0] rx_done_i,
    input logic            bus_rd_i,
    input logic            bus_wr_i,
    input logic            bus_rmw_i,
    input logic [7:0]      bus_wdata_i,
    input logic [7:0]      bus_rdata_o,
    input logic [7:0]      stat_o
);
    logic any_ev;
    assign any_ev = node_evt_i | (|tx_done_i) | (|rx_done_i);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> stat_o == 8'h00);

    assert_node_record_R2: assert property (@(posedge clk) disable iff (rst)
        (node_evt_i && !(|tx_done_i) && !(|rx_done_i)) |=> stat_o == 8'h80);

    assert_tx_record_R3: assert property (@(posedge clk) disable iff (rst)
        ((|tx_done_i) && !(|rx_done_i)) |=> stat_o[7:4] == 4'h4);

    assert_rx_record_R4: assert property (@(posedge clk) disable iff (rst)
        (|rx_done_i) |=> stat_o[7:4] == 4'h2);

    assert_single_flag_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stat_o[7:5]));

    assert_write_and_R7: assert property (@(posedge clk) disable iff (rst)
        (!any_ev && bus_wr_i) |=> stat_o == ($past(stat_o) & $past(bus_wdata_i)));

    assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (rst)
        stat_o[4] == 1'b0);

    assert_rmw_read_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rmw_i |-> bus_rdata_o == 8'hEF);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!any_ev && !bus_wr_i) |=> $stable(stat_o));
endmodule

bind levt_reg levt_reg_chk #(.NBUF(NBUF)) chk_i (.*);

// File: tb/levt_reg_tb.sv
module levt_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        node_evt = 1'b0;
    logic [15:0] tx_done = '0;
    logic [15:0] rx_done = '0;
    logic        rd = 1'b0, wr = 1'b0, rmw = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, stat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    levt_reg dut_i (
        .clk(clk), .rst(rst), .node_evt_i(node_evt), .tx_done_i(tx_done),
        .rx_done_i(rx_done), .bus_rd_i(rd), .bus_wr_i(wr), .bus_rmw_i(rmw),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .stat_o(stat)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Present one cycle of stimulus, then remove it; result visible after one rising edge
    task automatic step(logic n, logic [15:0] tx, logic [15:0] rx, logic w, logic [7:0] d);
        @(negedge clk);
        node_evt = n; tx_done = tx; rx_done = rx; wr = w; wdata = d;
        @(negedge clk);
        node_evt = 0; tx_done = '0; rx_done = '0; wr = 0; wdata = '0;
    endtask

    task automatic t_reset;
        check("R1 reset value", stat, 8'h00);
        check("R1 reset read", rdata, 8'h00);
    endtask

    task automatic t_node;
        step(0, 16'h0200, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        check("R2 node clears index and flags", stat, 8'h80);
    endtask

    task automatic t_tx;
        step(0, 16'h0200, 0, 0, 0);
        check("R3 tx buffer 9", stat, 8'h49);
        step(0, 16'h0001, 0, 0, 0);
        check("R3 tx buffer 0", stat, 8'h40);
    endtask

    task automatic t_rx;
        step(0, 0, 16'h8000, 0, 0);
        check("R4 rx buffer 15", stat, 8'h2F);
        step(0, 0, 16'h0001, 0, 0);
        check("R4 rx buffer 0", stat, 8'h20);
    endtask

    task automatic t_lowest;
        step(0, 16'h0A30, 0, 0, 0);
        check("R5 tx lowest of several", stat, 8'h44);
        step(0, 0, 16'hFFFF, 0, 0);
        check("R5 rx all set", stat, 8'h20);
    endtask

    task automatic t_prio;
        step(1, 16'h0008, 16'h0080, 0, 0);
        check("R6 rx over tx over node", stat, 8'h27);
        step(1, 16'h0008, 0, 0, 0);
        check("R6 tx over node", stat, 8'h43);
    endtask

    task automatic t_write;
        step(0, 0, 16'h8000, 0, 0);
        step(0, 0, 0, 1, 8'hFF);
        check("R7 write ones keeps", stat, 8'h2F);
        step(0, 0, 0, 1, 8'hF5);
        check("R7 write zeros clear", stat, 8'h25);
        step(0, 0, 0, 1, 8'h00);
        check("R7 write all zero", stat, 8'h00);
    endtask

    task automatic t_rsv;
        step(0, 0, 0, 1, 8'h10);
        check("R8 bit4 write ignored", stat, 8'h00);
        step(0, 16'h0200, 0, 1, 8'hFF);
        step(0, 0, 0, 1, 8'hFF);
        check("R8 bit4 stays zero", stat, 8'h49);
    endtask

    task automatic t_rmw;
        @(negedge clk); rd = 1; #1;
        check("R9 plain read", rdata, 8'h49);
        rmw = 1; #1;
        check("R9 rmw read ones", rdata, 8'hEF);
        @(negedge clk); wr = 1; wdata = rdata;
        @(negedge clk); wr = 0; rmw = 0; rd = 0; wdata = 0;
        check("R9 rmw write-back keeps", stat, 8'h49);
    endtask

    task automatic t_collide;
        step(0, 0, 16'h0001, 0, 0);
        step(0, 16'h0004, 0, 1, 8'h00);
        check("R10 event beats write", stat, 8'h42);
    endtask

    task automatic t_hold;
        repeat (5) @(negedge clk);
        check("R11 idle hold", stat, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_node;
        t_tx;
        t_rx;
        t_lowest;
        t_prio;
        t_write;
        t_rsv;
        t_rmw;
        t_collide;
        t_hold;
        step(0, 0, 16'h0002, 0, 0);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R1 reset after activity", stat, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule